// File: doc/BRIEF.md
# Two-Arm Traffic Light Sequencer

This block sequences the signal heads of a crossing where two approaches (arm 1 and arm 2) meet and a pedestrian crossing shares the junction. A separate flow controller decides when a phase should end and raises `sw_req`. The sequencer turns that request into a safe series of light states. Each arm in turn shows straight/right green, amber, a protected left-turn arrow, and amber again. The other arm shows red for the whole time.

Pedestrian requests may arrive at any time. They are held in a latch and are served only after the running arm's final amber. The crossing then runs a steady walk interval followed by a flashing interval, with both arms red. After that, the arm that was not served last gets its green.

Intervals are measured in ticks. A tick is a clock cycle in which `tick_en` is high, so the timing unit is set by whatever pulses that enable.

Top module: `tl_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters idle. In idle both light codes are 00 (red), `ped_walk` and `ped_flash` are 0, and `cycle_done` is 0.
- R2: From idle, an edge with `sw_req` high starts arm 1 green (code 01) when `arm_sel` is 0, or arm 2 green when `arm_sel` is 1. At no time are both arms showing a code other than 00.
- R3: An arm's codes run in this order: 01 (straight/right green), 10 (amber), 11 (red with left arrow), 10 (amber), then 00. If no crossing is pending, the other arm's 01 follows at once.
- R4: The 01 and 11 states hold for as long as `sw_req` is low. They advance on the first edge that samples `sw_req` high.
- R5: Each amber state lasts exactly AMBER_TICKS ticks (default 2). It is left on the edge that samples the second `tick_en`-high cycle counted since the state began. Cycles with `tick_en` low do not count.
- R6: A `ped_req` pulse is latched and served after the running arm's second amber. During the crossing both arms show 00. `ped_walk` is high for WALK_TICKS ticks (default 10), then `ped_flash` is high for FLASH_TICKS ticks (default 5). The latch is cleared when the walk starts, unless `ped_req` is sampled on that same edge.
- R7: `cycle_done` is high for exactly one cycle: the first cycle after an arm's second amber ends. It is never high in two consecutive cycles.
- R8: After the flashing interval, the arm that did not run last gets green (01). `ped_req` seen in idle does not start a crossing from idle; in idle only `sw_req` starts an arm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timing tick enable |
| sw_req | input | 1 | Phase advance request from the flow controller |
| arm_sel | input | 1 | Arm chosen to start from idle (0 = arm 1, 1 = arm 2) |
| ped_req | input | 1 | Pedestrian request pulse |
| arm1_light | output | 2 | Arm 1 head: 00 red, 01 green, 10 amber, 11 red+left arrow |
| arm2_light | output | 2 | Arm 2 head, same encoding |
| ped_walk | output | 1 | Steady walk indication |
| ped_flash | output | 1 | Flashing (clearance) indication |
| cycle_done | output | 1 | One-cycle pulse at the end of an arm's sequence |

## Verification
All outputs are decoded from registered state. A change sampled on a rising edge appears on the outputs in the cycle right after that edge, and `cycle_done` rises in that same cycle, alongside the state that follows the final amber. The bench changes inputs on the falling edge and steps its reference model on the rising edge. It compares every output on the next falling edge, so each result is checked one edge after the stimulus that caused it. The directed interval checks count falling-edge samples, which gives the exact number of ticks each amber, walk and flash interval lasted.

// File: rtl/tl_seq_pkg.sv
package tl_seq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE   = 4'd0,
    PH_A_GO   = 4'd1,
    PH_A_AMB1 = 4'd2,
    PH_A_TURN = 4'd3,
    PH_A_AMB2 = 4'd4,
    PH_B_GO   = 4'd5,
    PH_B_AMB1 = 4'd6,
    PH_B_TURN = 4'd7,
    PH_B_AMB2 = 4'd8,
    PH_XWALK  = 4'd9,
    PH_XFLASH = 4'd10
  } phase_e;

  localparam logic [1:0] LT_RED   = 2'b00;
  localparam logic [1:0] LT_GO    = 2'b01;
  localparam logic [1:0] LT_AMBER = 2'b10;
  localparam logic [1:0] LT_TURN  = 2'b11;

  function automatic logic is_amber(phase_e ph);
    return (ph == PH_A_AMB1) || (ph == PH_A_AMB2) ||
           (ph == PH_B_AMB1) || (ph == PH_B_AMB2);
  endfunction

  function automatic logic is_held(phase_e ph);
    return (ph == PH_A_GO) || (ph == PH_A_TURN) ||
           (ph == PH_B_GO) || (ph == PH_B_TURN);
  endfunction

  function automatic logic is_timed(phase_e ph);
    return is_amber(ph) || (ph == PH_XWALK) || (ph == PH_XFLASH);
  endfunction

  // Tick budget of a phase; zero means the phase is not timed.
  function automatic int unsigned phase_limit(phase_e ph, int unsigned amb,
                                              int unsigned walk, int unsigned flash);
    if (is_amber(ph))       return amb;
    if (ph == PH_XWALK)     return walk;
    if (ph == PH_XFLASH)    return flash;
    return 0;
  endfunction

  // Light code of one arm head (arm 0 = first arm) for a phase.
  function automatic logic [1:0] head_code(phase_e ph, logic arm);
    logic [3:0] base;
    logic [3:0] rel;
    base = arm ? 4'd5 : 4'd1;
    if (ph < base || ph > base + 4'd3) return LT_RED;
    rel = ph - base;
    case (rel)
      4'd0:    return LT_GO;
      4'd2:    return LT_TURN;
      default: return LT_AMBER;
    endcase
  endfunction

endpackage

// File: rtl/tl_tick_timer.sv
module tl_tick_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             asrt_live;

  always_ff @(posedge clk) begin
    if (rst)                            cnt <= '0;
    else if (restart)                   cnt <= '0;
    else if (tick_en && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expire = tick_en && (limit != '0) && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) asrt_live <= 1'b0;
    else     asrt_live <= 1'b1;
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    (limit != '0) |-> (cnt < limit)); // R5

  AST_CNT_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    (!tick_en && !restart) |=> $stable(cnt)); // R5

endmodule

// File: rtl/tl_ped_latch.sv
module tl_ped_latch (
  input  logic clk,
  input  logic rst,
  input  logic ped_req,
  input  logic take,
  output logic pend
);
  logic asrt_live;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= ped_req | (pend & ~take);
  end

  always_ff @(posedge clk) begin
    if (rst) asrt_live <= 1'b0;
    else     asrt_live <= 1'b1;
  end

  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    (pend && !take) |=> pend); // R6

  AST_REQ_CAPTURED: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    ped_req |=> pend); // R6

endmodule

// File: rtl/tl_phase_fsm.sv
module tl_phase_fsm
  import tl_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sw_req,
  input  logic   arm_sel,
  input  logic   ped_pend,
  input  logic   expire,
  output phase_e ph,
  output logic   ph_chg,
  output logic   enter_walk,
  output logic   arm_end
);
  phase_e nxt;
  logic   served_b;
  logic   asrt_live;

  always_comb begin
    nxt     = ph;
    arm_end = 1'b0;
    unique case (ph)
      PH_IDLE:   if (sw_req) nxt = arm_sel ? PH_B_GO : PH_A_GO;
      PH_A_GO:   if (sw_req) nxt = PH_A_AMB1;
      PH_A_AMB1: if (expire) nxt = PH_A_TURN;
      PH_A_TURN: if (sw_req) nxt = PH_A_AMB2;
      PH_A_AMB2: if (expire) begin
                   arm_end = 1'b1;
                   nxt     = ped_pend ? PH_XWALK : PH_B_GO;
                 end
      PH_B_GO:   if (sw_req) nxt = PH_B_AMB1;
      PH_B_AMB1: if (expire) nxt = PH_B_TURN;
      PH_B_TURN: if (sw_req) nxt = PH_B_AMB2;
      PH_B_AMB2: if (expire) begin
                   arm_end = 1'b1;
                   nxt     = ped_pend ? PH_XWALK : PH_A_GO;
                 end
      PH_XWALK:  if (expire) nxt = PH_XFLASH;
      PH_XFLASH: if (expire) nxt = served_b ? PH_A_GO : PH_B_GO;
      default:   nxt = PH_IDLE;
    endcase
  end

  assign ph_chg     = (nxt != ph);
  assign enter_walk = (nxt == PH_XWALK) && (ph != PH_XWALK);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      served_b <= 1'b0;
    end else begin
      ph <= nxt;
      if (arm_end) served_b <= (ph == PH_B_AMB2);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) asrt_live <= 1'b0;
    else     asrt_live <= 1'b1;
  end

  AST_HELD_WITHOUT_SW: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    (is_held(ph) && !sw_req) |=> (ph == $past(ph))); // R4

  AST_AMBER_WAITS: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    (is_timed(ph) && !expire) |=> (ph == $past(ph))); // R5

  AST_AMBER_LEAVES: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    (is_timed(ph) && expire) |=> (ph != $past(ph))); // R5

  AST_IDLE_IGNORES_PED: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    (ph == PH_IDLE && !sw_req) |=> (ph == PH_IDLE)); // R8

endmodule

// File: rtl/tl_head_decode.sv
module tl_head_decode
  import tl_seq_pkg::*;
#(
  parameter int unsigned N_ARMS = 2
) (
  input  phase_e                 ph,
  output logic [N_ARMS-1:0][1:0] heads,
  output logic                   walk,
  output logic                   flash
);
  for (genvar g = 0; g < N_ARMS; g++) begin : g_arm
    assign heads[g] = head_code(ph, g[0]);
  end

  assign walk  = (ph == PH_XWALK);
  assign flash = (ph == PH_XFLASH);
endmodule

// File: rtl/tl_sequencer.sv
module tl_sequencer
  import tl_seq_pkg::*;
#(
  parameter int unsigned AMBER_TICKS = 2,
  parameter int unsigned WALK_TICKS  = 10,
  parameter int unsigned FLASH_TICKS = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       sw_req,
  input  logic       arm_sel,
  input  logic       ped_req,
  output logic [1:0] arm1_light,
  output logic [1:0] arm2_light,
  output logic       ped_walk,
  output logic       ped_flash,
  output logic       cycle_done
);
  localparam int unsigned MAX_A = (AMBER_TICKS > WALK_TICKS) ? AMBER_TICKS : WALK_TICKS;
  localparam int unsigned MAX_T = (MAX_A > FLASH_TICKS) ? MAX_A : FLASH_TICKS;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  phase_e           ph;
  logic             ph_chg, enter_walk, arm_end, expire, ped_pend;
  logic [CNT_W-1:0] limit;
  logic [1:0][1:0]  heads;
  logic             asrt_live;

  assign limit = CNT_W'(phase_limit(ph, AMBER_TICKS, WALK_TICKS, FLASH_TICKS));

  tl_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .restart(ph_chg),
    .limit(limit), .expire(expire)
  );

  tl_ped_latch u_ped (
    .clk(clk), .rst(rst), .ped_req(ped_req), .take(enter_walk), .pend(ped_pend)
  );

  tl_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .sw_req(sw_req), .arm_sel(arm_sel),
    .ped_pend(ped_pend), .expire(expire), .ph(ph), .ph_chg(ph_chg),
    .enter_walk(enter_walk), .arm_end(arm_end)
  );

  tl_head_decode #(.N_ARMS(2)) u_dec (
    .ph(ph), .heads(heads), .walk(ped_walk), .flash(ped_flash)
  );

  assign arm1_light = heads[0];
  assign arm2_light = heads[1];

  always_ff @(posedge clk) begin
    if (rst) cycle_done <= 1'b0;
    else     cycle_done <= arm_end;
  end

  always_ff @(posedge clk) begin
    if (rst) asrt_live <= 1'b0;
    else     asrt_live <= 1'b1;
  end

  AST_ONE_ARM_OPEN: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    !((arm1_light != LT_RED) && (arm2_light != LT_RED))); // R2

  AST_CROSSING_ALL_RED: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    (ped_walk || ped_flash) |-> (arm1_light == LT_RED && arm2_light == LT_RED)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    cycle_done |=> !cycle_done); // R7

  AST_WALK_FOLLOWS_END: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    $rose(ped_walk) |-> cycle_done); // R6

  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst || !asrt_live)
    !(ped_walk && ped_flash)); // R6

endmodule

// File: tb/tl_sequencer_tb.sv
`timescale 1ns/1ps
module tl_sequencer_tb;
  logic clk = 1'b0;
  logic rst, tick_en, sw_req, arm_sel, ped_req;
  logic [1:0] arm1_light, arm2_light;
  logic ped_walk, ped_flash, cycle_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model: 0 idle, 1..4 arm1 (go, amb, turn, amb), 5..8 arm2, 9 walk, 10 flash
  int m_st, m_cnt;
  bit m_ped, m_last, m_done;

  always #2.5 clk = ~clk;

  tl_sequencer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .sw_req(sw_req), .arm_sel(arm_sel),
    .ped_req(ped_req), .arm1_light(arm1_light), .arm2_light(arm2_light),
    .ped_walk(ped_walk), .ped_flash(ped_flash), .cycle_done(cycle_done)
  );

  function automatic logic [1:0] exp_head(int st, int arm);
    int sub;
    if (st < 1 || st > 8) return 2'b00;
    if ((st - 1) / 4 != arm) return 2'b00;
    sub = (st - 1) % 4;
    if (sub == 0) return 2'b01;
    if (sub == 2) return 2'b11;
    return 2'b10;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(bit sw, bit as, bit pr, bit te);
    int nst, sub;
    bit leave;
    nst = m_st; leave = 0;
    if (m_st == 0) begin
      if (sw) nst = as ? 5 : 1;
    end else if (m_st <= 8) begin
      sub = (m_st - 1) % 4;
      if (sub == 0 || sub == 2) begin
        if (sw) nst = m_st + 1;
      end else if (te && m_cnt == 1) begin
        if (sub == 1) nst = m_st + 1;
        else begin
          leave  = 1;
          m_last = (m_st == 8);
          nst    = m_ped ? 9 : (m_st == 8 ? 1 : 5);
        end
      end
    end else if (m_st == 9) begin
      if (te && m_cnt == 9) nst = 10;
    end else if (te && m_cnt == 4) begin
      nst = m_last ? 1 : 5;
    end
    m_ped  = pr | (m_ped & !(nst == 9 && m_st != 9));
    m_cnt  = (nst != m_st) ? 0 : (te ? m_cnt + 1 : m_cnt);
    m_st   = nst;
    m_done = leave;
  endtask

  task automatic compare_all();
    check("R3 arm1_light", int'(arm1_light), int'(exp_head(m_st, 0)));
    check("R3 arm2_light", int'(arm2_light), int'(exp_head(m_st, 1)));
    check("R6 ped_walk",   int'(ped_walk),  (m_st == 9)  ? 1 : 0);
    check("R6 ped_flash",  int'(ped_flash), (m_st == 10) ? 1 : 0);
    check("R7 cycle_done", int'(cycle_done), int'(m_done));
  endtask

  task automatic step(bit sw, bit as, bit pr, bit te);
    sw_req = sw; arm_sel = as; ped_req = pr; tick_en = te;
    @(posedge clk);
    model_step(sw, as, pr, te);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20231));
    rst = 1'b1; tick_en = 0; sw_req = 0; arm_sel = 0; ped_req = 0;
    m_st = 0; m_cnt = 0; m_ped = 0; m_last = 0; m_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 arm1_light", int'(arm1_light), 0);
    check("R1 arm2_light", int'(arm2_light), 0);
    check("R1 ped_walk", int'(ped_walk), 0);
    check("R1 ped_flash", int'(ped_flash), 0);
    check("R1 cycle_done", int'(cycle_done), 0);
    rst = 1'b0;

    // R8: pedestrian request in idle does not leave idle
    step(0, 0, 1, 1);
    step(0, 0, 0, 1);
    check("R8 idle arm1", int'(arm1_light), 0);
    check("R8 idle walk", int'(ped_walk), 0);

    // R2: start arm 1
    step(1, 0, 0, 0);
    check("R2 arm1 green", int'(arm1_light), 1);
    check("R2 arm2 red", int'(arm2_light), 0);
    // R4: hold green without switch
    repeat (6) step(0, 1, 0, 1);
    check("R4 green held", int'(arm1_light), 1);
    step(1, 0, 0, 0);
    check("R4 advance to amber", int'(arm1_light), 2);
    // R5: no ticks keeps amber, then exactly two ticks
    repeat (4) step(0, 0, 0, 0);
    check("R5 amber waits for ticks", int'(arm1_light), 2);
    n = 0;
    while (arm1_light == 2'b10 && n < 20) begin step(0, 0, 0, 1); n++; end
    check("R5 amber tick count", n, 2);
    check("R3 left arrow", int'(arm1_light), 3);
    // R6: request mid-cycle is latched
    step(0, 0, 1, 1);
    step(1, 0, 0, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    check("R7 done after final amber", int'(cycle_done), 1);
    check("R6 walk begins", int'(ped_walk), 1);
    n = 1;
    while (ped_walk && n < 40) begin step(0, 0, 0, 1); if (ped_walk) n++; end
    check("R6 walk ticks", n, 10);
    n = 0;
    while (ped_flash && n < 40) begin n++; step(0, 0, 0, 1); end
    check("R6 flash ticks", n, 5);
    check("R8 other arm next", int'(arm2_light), 1);
    check("R8 served arm red", int'(arm1_light), 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) == 0, $urandom % 2, ($urandom % 16) == 0, ($urandom % 3) != 0);
    end
    // reset mid-run returns to idle
    rst = 1'b1;
    @(posedge clk);
    m_st = 0; m_cnt = 0; m_ped = 0; m_last = 0; m_done = 0;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset arm1", int'(arm1_light), 0);
    check("R1 reset arm2", int'(arm2_light), 0);
    step(1, 1, 0, 1);
    check("R2 arm2 start", int'(arm2_light), 1);
    check("R2 arm1 red", int'(arm1_light), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule